// File: doc/BRIEF.md
# Segmented Message Record/Playback Sequencer

This block is the digital controller of a solid-state message recorder whose storage is cut into a fixed number of equal time segments. A host, or a few switches, drives an active-low enable, a power-down line, a play/record select and an eight-bit address/mode bus. The controller holds the current segment pointer. It advances the pointer on each segment-boundary strobe. It keeps one end-of-message flag per segment and drives an active-low end-of-message pulse that a processor can use as a handshake, or that can feed the next device in a chain.

Values on the bus with both upper bits set are not addresses. They are six option flags that can be combined. The flags change how the pointer rewinds, how flags are written, whether each enable pulse skips to the next message, whether segment 0 replays in a loop, and whether playback follows the enable level rather than its falling edge. A low-supply input locks the device into playback only.

Top module: `msgrec_seq`

## Requirements
- R1: The segment pointer always lies in 0..NUM_SEGS-1 (default 0..159). While a recording runs, each `seg_tick` below the last segment advances the pointer by exactly one.
- R2: A falling edge of `ce_n` while `pd` is low and the block is idle captures `addr_mode` and `play_sel` (1 = playback, 0 = record). A value with bits 7:6 not both 1 is a direct start segment. A direct value of NUM_SEGS or more (160..191) starts nothing.
- R3: Each segment a recording enters has its flag cleared. A recording ended by `ce_n` high writes a flag at the current segment and moves the pointer to the next segment. A `seg_tick` in the last segment sets its flag, stops recording, enters overflow and pulses `eom_n`.
- R4: Playback checks the flag of the current segment at each `seg_tick`. On a flagged segment it stops, pulses `eom_n` low for exactly EOM_CYCLES clocks and rewinds the pointer to 0. An unflagged last segment ends playback as an overflow with an `eom_n` pulse.
- R5: When bits 7:6 are 11, bits 0..5 are the option flags M0..M5. An option-coded start uses the current pointer, except that playback after a recording starts at segment 0. `pd` high stops any operation, ends overflow and sets the pointer to 0 on the next clock; a recording stopped this way writes its flag first.
- R6: With M4, playback that ends on a flagged segment leaves the pointer at the segment after the flag.
- R7: With M0, each playback enable pulse starts no playback. It moves the pointer to the segment after the first flag at or beyond the start pointer, or to 0 if no such flag exists.
- R8: With M1, a recording that starts at segment s>0 clears the flag at s-1, so appended messages play back as one.
- R9: With M2, a flag reached in playback gives no `eom_n` pulse; overflow still pulses it.
- R10: With M3, playback starts at segment 0 and, on reaching a flag, returns to segment 0 and keeps playing.
- R11: With M5, playback starts at segment 0 and stops on the clock after `ce_n` goes high. Without M5, `ce_n` high does not stop playback.
- R12: While `low_supply` is 1, `eom_n` is low and record requests are refused; playback still starts.
- R13: `aux_sel` is 1 during overflow, and while idle with `ce_n` high after a playback; it is 0 after reset and after a recording.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, clears all flags |
| ce_n | input | 1 | Active-low enable |
| pd | input | 1 | Power-down, active high |
| play_sel | input | 1 | 1 playback, 0 record |
| addr_mode | input | 8 | Start segment or option flags |
| seg_tick | input | 1 | One-cycle strobe at the end of each segment slot |
| low_supply | input | 1 | Supply-low indication |
| eom_n | output | 1 | Active-low end-of-message / overflow pulse |
| seg_ptr | output | 8 | Current segment pointer |
| rec_active | output | 1 | Recording in progress |
| play_active | output | 1 | Playback in progress |
| aux_sel | output | 1 | Route auxiliary input to the output stage |

## Verification
A flag in the wrong segment shows up only later, as a playback that ends one or more ticks early or late, or as a false overflow. The bench therefore measures the number of ticks each playback lasts and compares it with the length that was recorded. A wrong pointer shows up on `seg_ptr` one clock after the enable edge or tick that moved it. A wrong option decode is seen within one message as a missing or extra `eom_n` pulse, or as playback that does not stop or rewind.

// File: rtl/msgrec_pkg.sv
package msgrec_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REC,
        ST_PLAY,
        ST_OVF
    } seq_state_e;

    // Option flags, packed so that a 6-bit bus slice casts in place (M5..M0).
    typedef struct packed {
        logic level;     // M5: playback follows enable level
        logic chain;     // M4: keep pointer after a flag
        logic loop;      // M3: replay segment-0 message
        logic quiet;     // M2: pulse only on overflow
        logic merge;     // M1: drop previous flag on append
        logic cue;       // M0: skip to next message
    } opt_t;

    function automatic logic is_opt_code(input logic [1:0] top_bits);
        return &top_bits;
    endfunction

endpackage

// File: rtl/msgrec_pulse.sv
module msgrec_pulse #(
    parameter int WIDTH = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic active
);
    localparam int CW = $clog2(WIDTH + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (fire)
            cnt <= CW'(WIDTH);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign active = (cnt != '0);
endmodule

// File: rtl/msgrec_marks.sv
module msgrec_marks #(
    parameter int NUM_SEGS = 160,
    parameter int ADDR_W   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] set_idx,
    input  logic              clr_a_en,
    input  logic [ADDR_W-1:0] clr_a_idx,
    input  logic              clr_b_en,
    input  logic [ADDR_W-1:0] clr_b_idx,
    input  logic [ADDR_W-1:0] rd_idx,
    input  logic [ADDR_W-1:0] cue_from,
    output logic              rd_mark,
    output logic [ADDR_W-1:0] cue_seg
);
    logic [NUM_SEGS-1:0] marks;

    always_ff @(posedge clk) begin
        if (rst) begin
            marks <= '0;
        end else begin
            for (int i = 0; i < NUM_SEGS; i++) begin
                if (set_en && set_idx == ADDR_W'(i))
                    marks[i] <= 1'b1;
                else if ((clr_a_en && clr_a_idx == ADDR_W'(i)) ||
                         (clr_b_en && clr_b_idx == ADDR_W'(i)))
                    marks[i] <= 1'b0;
            end
        end
    end

    always_comb begin
        rd_mark = 1'b0;
        for (int i = 0; i < NUM_SEGS; i++)
            if (rd_idx == ADDR_W'(i)) rd_mark = marks[i];
    end

    // First flag at or above cue_from; the segment after it, wrapping to 0.
    always_comb begin
        cue_seg = '0;
        for (int i = NUM_SEGS - 1; i >= 0; i--) begin
            if (ADDR_W'(i) >= cue_from && marks[i])
                cue_seg = (i == NUM_SEGS - 1) ? '0 : ADDR_W'(i + 1);
        end
    end
endmodule

// File: rtl/msgrec_seq.sv
module msgrec_seq
    import msgrec_pkg::*;
#(
    parameter int NUM_SEGS   = 160,
    parameter int ADDR_W     = 8,
    parameter int EOM_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ce_n,
    input  logic              pd,
    input  logic              play_sel,
    input  logic [ADDR_W-1:0] addr_mode,
    input  logic              seg_tick,
    input  logic              low_supply,
    output logic              eom_n,
    output logic [ADDR_W-1:0] seg_ptr,
    output logic              rec_active,
    output logic              play_active,
    output logic              aux_sel
);
    localparam logic [ADDR_W-1:0] LAST_SEG = ADDR_W'(NUM_SEGS - 1);

    seq_state_e        state, state_n;
    logic [ADDR_W-1:0] ptr, ptr_n;
    logic              ce_q, ce_fall;
    logic              q_level, q_chain, q_loop, q_quiet;
    logic              q_level_n, q_chain_n, q_loop_n, q_quiet_n;
    logic              last_rec, last_rec_n, played, played_n;

    logic              is_opt, cmd_ok;
    opt_t              opt;
    logic [ADDR_W-1:0] start_seg, play_seg;

    logic              set_en, clr_a_en, clr_b_en, rd_mark, fire, pulse_on;
    logic [ADDR_W-1:0] set_idx, clr_a_idx, clr_b_idx, cue_seg;

    assign ce_fall = ce_q & ~ce_n;

    // Command decode of the captured bus value.
    always_comb begin
        is_opt    = is_opt_code(addr_mode[ADDR_W-1:ADDR_W-2]);
        opt       = is_opt ? opt_t'(addr_mode[5:0]) : '0;
        cmd_ok    = is_opt || (addr_mode <= LAST_SEG);
        start_seg = is_opt ? ptr : addr_mode;
        play_seg  = (is_opt && (last_rec || opt.loop || opt.level)) ? '0 : start_seg;
    end

    msgrec_marks #(.NUM_SEGS(NUM_SEGS), .ADDR_W(ADDR_W)) u_marks (
        .clk      (clk),
        .rst      (rst),
        .set_en   (set_en),
        .set_idx  (set_idx),
        .clr_a_en (clr_a_en),
        .clr_a_idx(clr_a_idx),
        .clr_b_en (clr_b_en),
        .clr_b_idx(clr_b_idx),
        .rd_idx   (ptr),
        .cue_from (play_seg),
        .rd_mark  (rd_mark),
        .cue_seg  (cue_seg)
    );

    msgrec_pulse #(.WIDTH(EOM_CYCLES)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .fire  (fire),
        .active(pulse_on)
    );

    always_comb begin
        state_n    = state;
        ptr_n      = ptr;
        q_level_n  = q_level;
        q_chain_n  = q_chain;
        q_loop_n   = q_loop;
        q_quiet_n  = q_quiet;
        last_rec_n = last_rec;
        played_n   = played;
        set_en     = 1'b0;
        set_idx    = ptr;
        clr_a_en   = 1'b0;
        clr_a_idx  = ptr;
        clr_b_en   = 1'b0;
        clr_b_idx  = start_seg - 1'b1;
        fire       = 1'b0;

        if (pd) begin
            if (state == ST_REC)  set_en   = 1'b1;
            if (state == ST_PLAY) played_n = 1'b1;
            state_n = ST_IDLE;
            ptr_n   = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (ce_fall && cmd_ok) begin
                        q_level_n = opt.level;
                        q_chain_n = opt.chain;
                        q_loop_n  = opt.loop;
                        q_quiet_n = opt.quiet;
                        if (!play_sel) begin
                            if (!low_supply) begin
                                state_n    = ST_REC;
                                ptr_n      = start_seg;
                                last_rec_n = 1'b1;
                                played_n   = 1'b0;
                                clr_a_en   = 1'b1;
                                clr_a_idx  = start_seg;
                                clr_b_en   = opt.merge && (start_seg != '0);
                            end
                        end else begin
                            last_rec_n = 1'b0;
                            played_n   = 1'b0;
                            if (opt.cue) begin
                                ptr_n = cue_seg;
                            end else begin
                                state_n = ST_PLAY;
                                ptr_n   = play_seg;
                            end
                        end
                    end
                end
                ST_REC: begin
                    if (ce_n) begin
                        set_en  = 1'b1;
                        ptr_n   = (ptr == LAST_SEG) ? ptr : ptr + 1'b1;
                        state_n = ST_IDLE;
                    end else if (seg_tick) begin
                        if (ptr == LAST_SEG) begin
                            set_en  = 1'b1;
                            fire    = 1'b1;
                            state_n = ST_OVF;
                        end else begin
                            ptr_n     = ptr + 1'b1;
                            clr_a_en  = 1'b1;
                            clr_a_idx = ptr + 1'b1;
                        end
                    end
                end
                ST_PLAY: begin
                    if (q_level && ce_n) begin
                        state_n  = ST_IDLE;
                        played_n = 1'b1;
                    end else if (seg_tick) begin
                        if (rd_mark) begin
                            fire = !q_quiet;
                            if (q_loop) begin
                                ptr_n = '0;
                            end else begin
                                state_n  = ST_IDLE;
                                played_n = 1'b1;
                                ptr_n    = (q_chain && ptr != LAST_SEG) ? ptr + 1'b1 : '0;
                            end
                        end else if (ptr == LAST_SEG) begin
                            fire     = 1'b1;
                            played_n = 1'b1;
                            state_n  = ST_OVF;
                        end else begin
                            ptr_n = ptr + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            ptr      <= '0;
            ce_q     <= 1'b1;
            q_level  <= 1'b0;
            q_chain  <= 1'b0;
            q_loop   <= 1'b0;
            q_quiet  <= 1'b0;
            last_rec <= 1'b0;
            played   <= 1'b0;
        end else begin
            state    <= state_n;
            ptr      <= ptr_n;
            ce_q     <= ce_n;
            q_level  <= q_level_n;
            q_chain  <= q_chain_n;
            q_loop   <= q_loop_n;
            q_quiet  <= q_quiet_n;
            last_rec <= last_rec_n;
            played   <= played_n;
        end
    end

    assign seg_ptr     = ptr;
    assign rec_active  = (state == ST_REC);
    assign play_active = (state == ST_PLAY);
    assign eom_n       = ~(pulse_on | low_supply);
    assign aux_sel     = (state == ST_OVF) || (state == ST_IDLE && ce_n && played);
endmodule

// File: rtl/msgrec_seq_chk.sv
module msgrec_seq_chk #(
    parameter int NUM_SEGS = 160,
    parameter int ADDR_W   = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ce_n,
    input logic              pd,
    input logic              seg_tick,
    input logic              low_supply,
    input logic              eom_n,
    input logic [ADDR_W-1:0] seg_ptr,
    input logic              rec_active,
    input logic              play_active,
    input logic              aux_sel
);
    localparam logic [ADDR_W-1:0] LAST_SEG = ADDR_W'(NUM_SEGS - 1);

    assert_ptr_range_R1: assert property (@(posedge clk) disable iff (rst)
        seg_ptr <= LAST_SEG);

    assert_rec_step_R1: assert property (@(posedge clk) disable iff (rst)
        (rec_active && seg_tick && !ce_n && !pd && seg_ptr != LAST_SEG)
        |=> seg_ptr == $past(seg_ptr) + 1'b1);

    assert_rec_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (rec_active && seg_tick && !ce_n && !pd && seg_ptr == LAST_SEG)
        |=> (!rec_active && aux_sel && !eom_n));

    assert_pd_rewind_R5: assert property (@(posedge clk) disable iff (rst)
        pd |=> (seg_ptr == '0 && !rec_active && !play_active));

    assert_low_eom_R12: assert property (@(posedge clk) disable iff (rst)
        low_supply |-> !eom_n);

    assert_low_no_rec_R12: assert property (@(posedge clk) disable iff (rst)
        (low_supply && !rec_active) |=> !rec_active);
endmodule

bind msgrec_seq msgrec_seq_chk #(.NUM_SEGS(NUM_SEGS), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .ce_n       (ce_n),
    .pd         (pd),
    .seg_tick   (seg_tick),
    .low_supply (low_supply),
    .eom_n      (eom_n),
    .seg_ptr    (seg_ptr),
    .rec_active (rec_active),
    .play_active(play_active),
    .aux_sel    (aux_sel)
);

// File: tb/tb_msgrec_seq.sv
module tb_msgrec_seq;
    localparam int CLK_PERIOD = 10;
    localparam int EOM_W      = 4;

    logic       clk = 1'b0;
    logic       rst, ce_n, pd, play_sel, seg_tick, low_supply;
    logic [7:0] addr_mode;
    logic       eom_n, rec_active, play_active, aux_sel;
    logic [7:0] seg_ptr;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    msgrec_seq #(.NUM_SEGS(160), .ADDR_W(8), .EOM_CYCLES(EOM_W)) dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .pd(pd), .play_sel(play_sel),
        .addr_mode(addr_mode), .seg_tick(seg_tick), .low_supply(low_supply),
        .eom_n(eom_n), .seg_ptr(seg_ptr), .rec_active(rec_active),
        .play_active(play_active), .aux_sel(aux_sel)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1; ce_n = 1'b1; pd = 1'b0; play_sel = 1'b0;
        seg_tick = 1'b0; low_supply = 1'b0; addr_mode = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic start(input logic [7:0] a, input logic sel, input bit keep_low);
        @(negedge clk);
        addr_mode = a; play_sel = sel; ce_n = 1'b0;
        @(negedge clk);
        if (!keep_low) ce_n = 1'b1;
    endtask

    task automatic ce_high();
        @(negedge clk); ce_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic tick();
        @(negedge clk); seg_tick = 1'b1;
        @(negedge clk); seg_tick = 1'b0;
    endtask

    task automatic pd_pulse();
        @(negedge clk); pd = 1'b1; ce_n = 1'b1;
        @(negedge clk); pd = 1'b0;
    endtask

    task automatic run_play(output int n, output int eom_seen);
        n = 0; eom_seen = 0;
        while (play_active && n < 200) begin
            tick();
            n++;
            if (!eom_n) eom_seen = 1;
        end
    endtask

    task automatic record(input logic [7:0] a, input int len);
        start(a, 1'b0, 1'b1);
        repeat (len) tick();
        ce_high();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int n, e, w;
        int starts[5] = '{0, 37, 80, 121, 155};

        do_reset();
        chk("R13 reset eom_n", eom_n, 1);
        chk("R13 reset ptr", seg_ptr, 0);
        chk("R13 reset rec", rec_active, 0);
        chk("R13 reset play", play_active, 0);
        chk("R13 reset aux", aux_sel, 0);

        // R1 R3 R4: sweep of start segment and message length
        foreach (starts[k]) begin
            for (int len = 0; len < 4; len++) begin
                do_reset();
                start(8'(starts[k]), 1'b0, 1'b1);
                chk("R2 record start", rec_active, 1);
                chk("R2 record start ptr", seg_ptr, starts[k]);
                repeat (len) tick();
                chk("R1 ptr after ticks", seg_ptr, starts[k] + len);
                ce_high();
                chk("R3 record stopped", rec_active, 0);
                chk("R3 ptr after stop", seg_ptr, starts[k] + len + 1);
                chk("R13 aux after record", aux_sel, 0);
                start(8'(starts[k]), 1'b1, 1'b0);
                chk("R2 play start", play_active, 1);
                chk("R2 play start ptr", seg_ptr, starts[k]);
                if (len > 0) begin
                    tick();
                    chk("R11 edge play keeps running", play_active, 1);
                    run_play(n, e);
                    n++;
                end else begin
                    run_play(n, e);
                end
                chk("R4 play length", n, len + 1);
                chk("R4 eom pulse", e, 1);
                chk("R4 ptr rewound", seg_ptr, 0);
                chk("R13 aux after play", aux_sel, 1);
                if (k == 0 && len == 0) begin
                    w = 0;
                    while (!eom_n && w < 50) begin w++; @(negedge clk); end
                    chk("R4 eom width", w, EOM_W);
                end
            end
        end

        // R3: record overflow at the last segment
        do_reset();
        start(8'd158, 1'b0, 1'b1);
        tick();
        chk("R1 ptr to last", seg_ptr, 159);
        tick();
        chk("R3 overflow stops rec", rec_active, 0);
        chk("R3 overflow eom", eom_n, 0);
        chk("R13 overflow aux", aux_sel, 1);
        chk("R3 overflow ptr", seg_ptr, 159);
        pd_pulse();
        chk("R5 pd ptr", seg_ptr, 0);
        chk("R13 aux after pd", aux_sel, 0);
        start(8'd158, 1'b1, 1'b0);
        run_play(n, e);
        chk("R3 overflow flag at last", n, 2);

        // R4: unflagged playback runs into overflow
        do_reset();
        start(8'd157, 1'b1, 1'b0);
        run_play(n, e);
        chk("R4 play overflow length", n, 3);
        chk("R4 play overflow eom", e, 1);
        chk("R13 play overflow aux", aux_sel, 1);
        pd_pulse();

        // R3: a recording clears flags it passes
        do_reset();
        record(8'd10, 0);
        record(8'd8, 3);
        start(8'd8, 1'b1, 1'b0);
        run_play(n, e);
        chk("R3 old flag cleared", n, 4);

        // R5: power-down during record writes flag, rewinds
        do_reset();
        start(8'd20, 1'b0, 1'b1);
        tick();
        pd_pulse();
        chk("R5 pd stops rec", rec_active, 0);
        chk("R5 pd ptr zero", seg_ptr, 0);
        start(8'd20, 1'b1, 1'b0);
        run_play(n, e);
        chk("R5 pd wrote flag", n, 2);

        // R2: out-of-range direct addresses ignored
        do_reset();
        start(8'd170, 1'b1, 1'b0);
        chk("R2 bad addr no play", play_active, 0);
        chk("R2 bad addr ptr", seg_ptr, 0);
        start(8'd191, 1'b0, 1'b1);
        chk("R2 bad addr no rec", rec_active, 0);
        ce_high();

        // R5 R6 R7: option records, cueing, chained playback
        do_reset();
        start(8'hC0, 1'b0, 1'b1);
        chk("R5 first option op at 0", seg_ptr, 0);
        repeat (2) tick();
        ce_high();
        chk("R3 option rec ptr", seg_ptr, 3);
        start(8'hC0, 1'b0, 1'b1);
        chk("R5 option rec continues", seg_ptr, 3);
        tick();
        ce_high();
        start(8'hC1, 1'b1, 1'b0);
        chk("R7 cue first", seg_ptr, 3);
        chk("R7 cue no play", play_active, 0);
        start(8'hC1, 1'b1, 1'b0);
        chk("R7 cue second", seg_ptr, 5);
        start(8'hC1, 1'b1, 1'b0);
        chk("R7 cue wrap", seg_ptr, 0);
        start(8'hD0, 1'b1, 1'b0);
        run_play(n, e);
        chk("R6 chain len 1", n, 3);
        chk("R6 chain ptr 1", seg_ptr, 3);
        start(8'hD0, 1'b1, 1'b0);
        run_play(n, e);
        chk("R6 chain len 2", n, 2);
        chk("R6 chain ptr 2", seg_ptr, 5);

        // R8: merge on append
        do_reset();
        record(8'hC0, 2);
        record(8'hC2, 1);
        start(8'hC0, 1'b1, 1'b0);
        chk("R5 rec-to-play rewind", seg_ptr, 0);
        run_play(n, e);
        chk("R8 merged length", n, 5);

        // R9: quiet option
        do_reset();
        record(8'hC0, 1);
        start(8'hC4, 1'b1, 1'b0);
        run_play(n, e);
        chk("R9 quiet len", n, 2);
        chk("R9 no eom on flag", e, 0);
        start(8'hD4, 1'b1, 1'b0);
        run_play(n, e);
        chk("R9 quiet chain ptr", seg_ptr, 2);
        start(8'hD4, 1'b1, 1'b0);
        run_play(n, e);
        chk("R9 overflow len", n, 158);
        chk("R9 overflow eom", e, 1);
        pd_pulse();

        // R10: loop
        do_reset();
        record(8'hC0, 1);
        start(8'hC8, 1'b1, 1'b0);
        chk("R10 loop start", seg_ptr, 0);
        tick();
        chk("R10 loop step", seg_ptr, 1);
        tick();
        chk("R10 loop back", seg_ptr, 0);
        chk("R10 loop playing", play_active, 1);
        chk("R10 loop eom", eom_n, 0);
        repeat (2) tick();
        chk("R10 loop again", play_active, 1);
        pd_pulse();
        chk("R5 pd stops loop", play_active, 0);

        // R11: level-sensitive playback
        do_reset();
        record(8'hC0, 3);
        start(8'hE0, 1'b1, 1'b1);
        chk("R11 level start 0", seg_ptr, 0);
        tick();
        chk("R11 level running", play_active, 1);
        ce_high();
        chk("R11 level stop", play_active, 0);

        // R12: low supply
        do_reset();
        low_supply = 1'b1;
        @(negedge clk);
        chk("R12 eom held low", eom_n, 0);
        start(8'd30, 1'b0, 1'b1);
        chk("R12 rec refused", rec_active, 0);
        chk("R12 ptr unchanged", seg_ptr, 0);
        ce_high();
        start(8'd30, 1'b1, 1'b0);
        chk("R12 play allowed", play_active, 1);
        pd_pulse();
        low_supply = 1'b0;
        @(negedge clk);
        chk("R12 eom released", eom_n, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule